// File: doc/BRIEF.md
# GCR Write Serializer

This block turns a stream of data bytes into the serial bit sequence that a disk write channel records. Each byte becomes a 10-bit group-coded word: the high nibble and the low nibble are each mapped to a 5-bit code, and the two codes are placed side by side. The code table keeps no run of more than two zeros, so the read side can stay locked to the flux. A write-sync flag replaces the data word with an all-ones sync word, which marks the start of a field.

The host raises write mode and presents a byte together with the sync flag. On every bit-cell strobe the block sends one bit, most significant first. A modulo-10 bit counter marks the byte boundaries. At each boundary the block loads the next encoded word and pulses a byte request for one clock. The host answers that pulse by presenting the following byte. Outside write mode the serial output is held low and strobes have no effect.

Top module: `gcr_write_serializer`

## Requirements
- R1: After reset, `wr_bit` and `byte_req` are both 0.
- R2: In write mode the bit counter advances by one on each strobe and wraps from 9 to 0, so one word lasts exactly 10 strobes. The first strobe after write mode is entered is a byte boundary.
- R3: A strobe on a byte boundary loads the encoded word from `wr_data`/`wr_sync` into the 10-bit shift register. From the clock after that strobe, `wr_bit` shows the register's bit 9.
- R4: A strobe that is not on a boundary shifts the register left by one and fills a zero at the bottom. With no strobe, the register and `wr_bit` hold their values.
- R5: With `wr_sync` at 0, the word is {C(d[7:4]), C(d[3:0])}, high code first. C maps nibbles 0..F to 01010, 01011, 10010, 10011, 01110, 01111, 10110, 10111, 01001, 11001, 11010, 11011, 01101, 11101, 11110, 10101.
- R6: With `wr_sync` at 1, the word is 10'h3FF, whatever the value of `wr_data`.
- R7: `byte_req` is high for exactly one clock, in the clock after each load, and is low at all other times.
- R8: While `wr_en` is 0, `wr_bit` is 0 and strobes are ignored. Re-entering write mode starts a fresh word at the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_strobe | input | 1 | One-clock pulse per bit cell |
| wr_en | input | 1 | Write mode active when high |
| wr_data | input | 8 | Byte to encode at the next boundary |
| wr_sync | input | 1 | Send the sync word instead of data |
| wr_bit | output | 1 | Serial write bit |
| byte_req | output | 1 | One-clock request for the next byte |

## Verification
On every cycle, the assertions check the following:
- the counter stays in range and wraps to zero after a boundary strobe;
- the shift register either takes the encoder's word, shifts by one, or holds, according to the strobe and the boundary;
- the encoder gives all ones whenever sync is requested;
- `byte_req` never lasts more than one clock;
- `wr_bit` is low outside write mode.

Only the bench's scenarios can show that the bit order on the wire matches the nibble code table, and that a word lasts exactly ten strobes whether the strobes come back to back or with gaps. They also show that leaving write mode in the middle of a word, and entering it again, restarts cleanly on a fresh word.

// File: rtl/gcr_ser_pkg.sv
package gcr_ser_pkg;

  localparam int unsigned GCR_WORD_W = 10;
  localparam int unsigned GCR_DATA_W = 8;

  // 4-bit nibble to 5-bit group code (no more than two zeros in a row)
  function automatic logic [4:0] gcr_nibble(input logic [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'b01010;
      4'h1: c = 5'b01011;
      4'h2: c = 5'b10010;
      4'h3: c = 5'b10011;
      4'h4: c = 5'b01110;
      4'h5: c = 5'b01111;
      4'h6: c = 5'b10110;
      4'h7: c = 5'b10111;
      4'h8: c = 5'b01001;
      4'h9: c = 5'b11001;
      4'hA: c = 5'b11010;
      4'hB: c = 5'b11011;
      4'hC: c = 5'b01101;
      4'hD: c = 5'b11101;
      4'hE: c = 5'b11110;
      default: c = 5'b10101;
    endcase
    return c;
  endfunction

  // Write-side table index: top bit marks the write half of the table
  function automatic logic [9:0] wr_index(input logic [7:0] d, input logic s);
    return {1'b1, d[7:4], s, d[3:0]};
  endfunction

  // 8-bit table output; the middle bit of each code equals the matching
  // nibble's bit 2, so it is taken from the index instead of the table
  function automatic logic [7:0] wr_lookup(input logic [9:0] idx);
    logic [4:0] h;
    logic [4:0] l;
    if (idx[4]) return 8'hFF;
    h = gcr_nibble(idx[8:5]);
    l = gcr_nibble(idx[3:0]);
    return {h[4], h[3], h[1], h[0], l[4], l[3], l[1], l[0]};
  endfunction

  // Interleave table output and index bits into the 10-bit line word
  function automatic logic [9:0] pack_word(input logic [7:0] e, input logic [9:0] idx);
    logic s;
    s = idx[4];
    return {e[7], e[6], idx[7] | s, e[5], e[4], e[3], e[2], idx[2] | s, e[1], e[0]};
  endfunction

endpackage

// File: rtl/gcr_bit_counter.sv
module gcr_bit_counter #(
  parameter int unsigned MODULUS = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         step,
  output logic [$clog2(MODULUS)-1:0]   cnt,
  output logic                         boundary
);
  localparam int unsigned CNT_W = $clog2(MODULUS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

  assign boundary = (cnt == LAST);

  // Parked on the boundary outside write mode so the first strobe loads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= LAST;
    else if (!wr_en)     cnt <= LAST;
    else if (step)       cnt <= boundary ? '0 : cnt + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && step && boundary) |=> (cnt == '0));

  p_cnt_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && step && !boundary) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/gcr_write_encoder.sv
module gcr_write_encoder
  import gcr_ser_pkg::*;
(
  input  logic [GCR_DATA_W-1:0] data,
  input  logic                  sync,
  output logic [9:0]            index,
  output logic [7:0]            lut_out,
  output logic [GCR_WORD_W-1:0] word
);
  always_comb begin
    index   = wr_index(data, sync);
    lut_out = wr_lookup(index);
    word    = pack_word(lut_out, index);
  end
endmodule

// File: rtl/gcr_shift_out.sv
module gcr_shift_out #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (!wr_en) q <= '0;
    else if (load)   q <= word;
    else if (shift)  q <= {q[WORD_W-2:0], 1'b0};
  end

  p_load_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && load) |=> (q == $past(word)));

  p_shift_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && shift && !load) |=> (q == {$past(q[WORD_W-2:0]), 1'b0}));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !shift && !load) |=> $stable(q));

endmodule

// File: rtl/gcr_write_serializer.sv
module gcr_write_serializer
  import gcr_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_strobe,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_sync,
  output logic       wr_bit,
  output logic       byte_req
);
  localparam int unsigned CNT_W = $clog2(GCR_WORD_W);

  logic [CNT_W-1:0]      bit_cnt;
  logic                  at_boundary;
  logic                  load_evt;
  logic                  shift_evt;
  logic [9:0]            enc_index;
  logic [7:0]            enc_lut;
  logic [GCR_WORD_W-1:0] enc_word;
  logic [GCR_WORD_W-1:0] shreg;
  logic                  req_q;

  gcr_bit_counter #(.MODULUS(GCR_WORD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .step     (bit_strobe),
    .cnt      (bit_cnt),
    .boundary (at_boundary)
  );

  gcr_write_encoder u_enc (
    .data    (wr_data),
    .sync    (wr_sync),
    .index   (enc_index),
    .lut_out (enc_lut),
    .word    (enc_word)
  );

  // Named events for the checks
  assign load_evt  = wr_en & bit_strobe & at_boundary;
  assign shift_evt = wr_en & bit_strobe & ~at_boundary;

  gcr_shift_out #(.WORD_W(GCR_WORD_W)) u_sh (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .load  (load_evt),
    .shift (shift_evt),
    .word  (enc_word),
    .q     (shreg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= load_evt;
  end

  assign wr_bit   = wr_en & shreg[GCR_WORD_W-1];
  assign byte_req = req_q;

  p_sync_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sync |-> (enc_word == '1));

  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !byte_req);

  p_req_follows_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> byte_req);

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_bit);

endmodule

// File: tb/gcr_write_serializer_tb.sv
module gcr_write_serializer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_strobe = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_sync = 1'b0;
  logic       wr_bit;
  logic       byte_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gcr_write_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .wr_en(wr_en),
    .wr_data(wr_data), .wr_sync(wr_sync), .wr_bit(wr_bit), .byte_req(byte_req)
  );

  function automatic logic [4:0] code5(input logic [3:0] n);
    logic [4:0] t [16] = '{5'h0A, 5'h0B, 5'h12, 5'h13, 5'h0E, 5'h0F, 5'h16, 5'h17,
                           5'h09, 5'h19, 5'h1A, 5'h1B, 5'h0D, 5'h1D, 5'h1E, 5'h15};
    return t[n];
  endfunction

  function automatic logic [9:0] expect_word(input logic [7:0] d, input logic s);
    return s ? 10'h3FF : {code5(d[7:4]), code5(d[3:0])};
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, advance to the next falling edge
  task automatic step(input logic s);
    bit_strobe = s;
    @(negedge clk);
  endtask

  // Send one word; gap = idle clocks between strobes
  task automatic send_word(input logic [7:0] d, input logic s, input int gap, input string req);
    logic [9:0] got;
    wr_data = d;
    wr_sync = s;
    for (int k = 9; k >= 0; k--) begin
      step(1'b1);
      got[k] = wr_bit;
      chk("R7 byte_req", {9'd0, byte_req}, {9'd0, (k == 9)});
      for (int g = 0; g < gap; g++) begin
        step(1'b0);
        chk("R4 hold", {9'd0, wr_bit}, {9'd0, got[k]});
        chk("R7 no req in gap", {9'd0, byte_req}, 10'd0);
      end
    end
    chk(req, got, expect_word(d, s));
  endtask

  task automatic t_reset();
    chk("R1 wr_bit", {9'd0, wr_bit}, 10'd0);
    chk("R1 byte_req", {9'd0, byte_req}, 10'd0);
  endtask

  task automatic t_stream_back_to_back();
    wr_en = 1'b1;
    send_word(8'h00, 1'b0, 0, "R5 R2 R3 data 00");
    send_word(8'hFF, 1'b0, 0, "R5 data FF");
    send_word(8'h5A, 1'b0, 0, "R5 data 5A");
    send_word(8'h96, 1'b0, 0, "R5 data 96");
  endtask

  task automatic t_gapped();
    send_word(8'h3C, 1'b0, 2, "R4 R5 gapped 3C");
    send_word(8'hE1, 1'b0, 1, "R4 R5 gapped E1");
  endtask

  task automatic t_sync();
    send_word(8'h00, 1'b1, 0, "R6 sync data 00");
    send_word(8'hA5, 1'b1, 0, "R6 sync data A5");
    send_word(8'h84, 1'b0, 0, "R5 after sync 84");
  endtask

  task automatic t_idle_restart();
    logic [9:0] part;
    wr_data = 8'h12; wr_sync = 1'b0;
    for (int k = 9; k >= 6; k--) begin
      step(1'b1);
      part[k] = wr_bit;
    end
    chk("R3 partial word", {part[9:6], 6'd0}, {expect_word(8'h12, 1'b0) & 10'h3C0});
    wr_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step(k[0]);
      chk("R8 wr_bit low idle", {9'd0, wr_bit}, 10'd0);
      chk("R8 no req idle", {9'd0, byte_req}, 10'd0);
    end
    wr_en = 1'b1;
    step(1'b0);
    chk("R8 no output before strobe", {9'd0, wr_bit}, 10'd0);
    send_word(8'hC7, 1'b0, 0, "R8 R2 fresh word after restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream_back_to_back();
    t_gapped();
    t_sync();
    t_idle_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule